// File: doc/BRIEF.md
# Clock Gating Control Unit

This block decides, cycle by cycle, which clocks of a small subsystem may run. It owns one enable for the processor core clock and one enable per peripheral clock, and software drives both through a register bus. Each clock group has a write-one-to-set register, a write-one-to-clear register and a read-only status register. The enables leave the block as plain level signals. The gating cells that use them are outside the block.

The core enable is handled with more care than the peripheral enables. A software stop request does not switch the core clock off at once. The request waits until the processor signals that its current instruction is done. Any pending enabled interrupt brings the core clock back on by itself, and it also cancels a stop that is still waiting. Peripheral enables change in the cycle after the write, with no handshake. Their bit numbering follows the interrupt source numbering, so bit n gates the peripheral that raises interrupt n.

The DMA and peripheral data path clocks never depend on the core enable, so transfers continue while the core is asleep.

Top module: `ckg_ctrl`

## Requirements
- R1: The register map uses byte offsets, and an access counts only when the address is word aligned. Offset 0x00 is core set, 0x04 is core clear and 0x08 is core status, all on bit 0. Offset 0x10 is peripheral set, 0x14 is peripheral clear and 0x18 is peripheral status. Reads return data combinationally in the same cycle as the access.
- R2: After reset the core enable is 1 and every peripheral enable is 0.
- R3: A write of 1 to core-set while the core clock is off turns the core enable on in the cycle after the write.
- R4: A write of 1 to core-clear leaves the core enable at 1, and core status reading 1, until `core_insn_done` is sampled high. The core enable is 0 from the cycle after that sample.
- R5: When any bit of `irq_pend` is high while the core clock is off, the core enable returns to 1 in the next cycle.
- R6: When any bit of `irq_pend` is high while a core stop is still waiting, the stop is cancelled and the core clock stays on.
- R7: Writing 1 to bit n of peripheral-set enables peripheral clock n, and writing 1 to bit n of peripheral-clear disables it. Both take effect in the next cycle and need no handshake. Bit n corresponds to interrupt source n.
- R8: Bits written as 0 to any set or clear register change nothing.
- R9: Peripheral enables do not depend on the core enable. They keep their values, and can still be changed, while the core clock is off.
- R10: When `irq_pend` and `core_insn_done` are both high in the same cycle of a waiting stop, the interrupt wins and the core clock stays on.
- R11: Unaligned addresses and unmapped word offsets have no effect and read 0. Writes to the status registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the control unit |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the access |
| irq_pend | input | NPER | Enabled interrupts that are pending, one bit per source |
| core_insn_done | input | 1 | The processor has finished its current instruction |
| core_clk_en | output | 1 | Enable for the core clock |
| per_clk_en | output | NPER | Enables for the peripheral clocks, bit n for source n |

## Verification
Two events can land in the same cycle of a waiting core stop: an interrupt that should cancel the stop, and the instruction-complete handshake that should finish it. The bench writes core-clear, then raises one `irq_pend` bit and `core_insn_done` on the same falling edge. The core enable must still be 1 after the next rising edge. The stop must also be gone, so the enable stays on once both inputs drop. The same collision is covered from the other side: a core-clear write that arrives while an interrupt is pending must not end with the clock off.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

    // Word index of each register, taken from byte address bits [4:2].
    localparam int REG_IDX_W = 3;
    localparam int BUS_ADDR_W = REG_IDX_W + 2;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_CORE_SET  = 3'd0,
        IDX_CORE_CLR  = 3'd1,
        IDX_CORE_STAT = 3'd2,
        IDX_PER_SET   = 3'd4,
        IDX_PER_CLR   = 3'd5,
        IDX_PER_STAT  = 3'd6
    } reg_idx_e;

    // Life cycle of the core clock enable.
    typedef enum logic [1:0] {
        CORE_RUN      = 2'd0,
        CORE_STOPPING = 2'd1,
        CORE_OFF      = 2'd2
    } core_state_e;

    // Single-cycle commands from the bus decoder to the core controller.
    typedef struct packed {
        logic set_req;
        logic clr_req;
    } core_cmd_t;

    function automatic logic is_aligned(input logic [BUS_ADDR_W-1:0] a);
        return a[1:0] == 2'b00;
    endfunction

    function automatic logic [REG_IDX_W-1:0] word_idx(input logic [BUS_ADDR_W-1:0] a);
        return a[BUS_ADDR_W-1:2];
    endfunction

endpackage

// File: rtl/ckg_regbus.sv
module ckg_regbus
    import ckg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPER   = 32
) (
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  core_status,
    input  logic [NPER-1:0]       per_status,
    output core_cmd_t             core_cmd,
    output logic [NPER-1:0]       per_set,
    output logic [NPER-1:0]       per_clr
);

    logic       hit;
    logic       wr_hit;
    logic [REG_IDX_W-1:0] idx;

    assign hit    = bus_sel && is_aligned(bus_addr);
    assign wr_hit = hit && bus_wr;
    assign idx    = word_idx(bus_addr);

    // Write strobes: a bit written as 0 never produces a request.
    always_comb begin
        core_cmd.set_req = 1'b0;
        core_cmd.clr_req = 1'b0;
        per_set          = '0;
        per_clr          = '0;
        if (wr_hit) begin
            unique case (idx)
                IDX_CORE_SET: core_cmd.set_req = bus_wdata[0];
                IDX_CORE_CLR: core_cmd.clr_req = bus_wdata[0];
                IDX_PER_SET:  per_set          = bus_wdata[NPER-1:0];
                IDX_PER_CLR:  per_clr          = bus_wdata[NPER-1:0];
                default: ;
            endcase
        end
    end

    // Read path: only the status words return data.
    always_comb begin
        bus_rdata = '0;
        if (hit && !bus_wr) begin
            unique case (idx)
                IDX_CORE_STAT: bus_rdata[0]      = core_status;
                IDX_PER_STAT:  bus_rdata[NPER-1:0] = per_status;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ckg_core_ctrl.sv
module ckg_core_ctrl
    import ckg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  core_cmd_t cmd,
    input  logic      irq_any,
    input  logic      insn_done,
    output logic      core_en
);

    core_state_e state_q;
    core_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_RUN: begin
                if (cmd.clr_req) state_d = CORE_STOPPING;
            end
            CORE_STOPPING: begin
                // An interrupt or a fresh set cancels the stop, and wins over
                // a completion that arrives in the same cycle.
                if (irq_any || (cmd.set_req && !cmd.clr_req)) state_d = CORE_RUN;
                else if (insn_done)                           state_d = CORE_OFF;
            end
            CORE_OFF: begin
                if (irq_any || (cmd.set_req && !cmd.clr_req)) state_d = CORE_RUN;
            end
            default: state_d = CORE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CORE_RUN;
        else     state_q <= state_d;
    end

    assign core_en = (state_q != CORE_OFF);

    AST_STOP_WAITS_DONE: assert property (@(posedge clk) disable iff (rst)
        (core_en && !insn_done) |=> core_en); // R4

    AST_OFF_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(core_en) |-> $past(insn_done)); // R4

    AST_IRQ_WAKES_CORE: assert property (@(posedge clk) disable iff (rst)
        (!core_en && irq_any) |=> core_en); // R5

    AST_IRQ_BEATS_DONE: assert property (@(posedge clk) disable iff (rst)
        (core_en && irq_any) |=> core_en); // R10

endmodule

// File: rtl/ckg_per_bank.sv
module ckg_per_bank #(
    parameter int NPER = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPER-1:0] set_bits,
    input  logic [NPER-1:0] clr_bits,
    output logic [NPER-1:0] per_en
);

    // One enable flop per source; clear has priority within a bit.
    for (genvar n = 0; n < NPER; n++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)              per_en[n] <= 1'b0;
            else if (clr_bits[n]) per_en[n] <= 1'b0;
            else if (set_bits[n]) per_en[n] <= 1'b1;
        end
    end

    AST_PER_CLR_NEXT: assert property (@(posedge clk) disable iff (rst)
        (clr_bits != '0) |=> ((per_en & $past(clr_bits)) == '0)); // R7

    AST_PER_SET_NEXT: assert property (@(posedge clk) disable iff (rst)
        (set_bits != '0 && clr_bits == '0) |=> ((per_en & $past(set_bits)) == $past(set_bits))); // R7

    AST_PER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (set_bits == '0 && clr_bits == '0) |=> $stable(per_en)); // R8

endmodule

// File: rtl/ckg_ctrl.sv
module ckg_ctrl
    import ckg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPER   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NPER-1:0]       irq_pend,
    input  logic                  core_insn_done,
    output logic                  core_clk_en,
    output logic [NPER-1:0]       per_clk_en
);

    if (NPER > DATA_W || NPER < 1) begin : g_bad_width
        initial $error("NPER must lie between 1 and DATA_W");
    end

    core_cmd_t       core_cmd;
    logic [NPER-1:0] per_set;
    logic [NPER-1:0] per_clr;
    logic            irq_any;

    assign irq_any = |irq_pend;

    ckg_regbus #(.DATA_W(DATA_W), .NPER(NPER)) u_regbus (
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .core_status (core_clk_en),
        .per_status  (per_clk_en),
        .core_cmd    (core_cmd),
        .per_set     (per_set),
        .per_clr     (per_clr)
    );

    ckg_core_ctrl u_core (
        .clk       (clk),
        .rst       (rst),
        .cmd       (core_cmd),
        .irq_any   (irq_any),
        .insn_done (core_insn_done),
        .core_en   (core_clk_en)
    );

    // The peripheral bank sees no core state, so data transfers keep
    // running while the core sleeps.
    ckg_per_bank #(.NPER(NPER)) u_per (
        .clk      (clk),
        .rst      (rst),
        .set_bits (per_set),
        .clr_bits (per_clr),
        .per_en   (per_clk_en)
    );

    AST_PER_IGNORES_CORE: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel && $fell(core_clk_en)) |-> $stable(per_clk_en)); // R9

endmodule

// File: tb/tb_ckg_ctrl.sv
module tb_ckg_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NP-1:0] irq_pend = '0;
    logic          core_insn_done = 1'b0;
    logic          core_clk_en;
    logic [NP-1:0] per_clk_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckg_ctrl #(.DATA_W(DW), .NPER(NP)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pend(irq_pend), .core_insn_done(core_insn_done),
        .core_clk_en(core_clk_en), .per_clk_en(per_clk_en)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic stop_core();
        bus_write(5'h04, 32'h1);
        core_insn_done = 1'b1;
        @(negedge clk);
        core_insn_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] r;
        check("R2 core on after reset", {31'b0, core_clk_en}, 32'h1);
        check("R2 periph off after reset", per_clk_en, 32'h0);
        bus_read(5'h08, r);
        check("R1 core status after reset", r, 32'h1);
    endtask

    task automatic t_core_stop();
        logic [DW-1:0] r;
        bus_write(5'h04, 32'h1);
        check("R4 core on while stop waits", {31'b0, core_clk_en}, 32'h1);
        repeat (3) @(negedge clk);
        bus_read(5'h08, r);
        check("R4 status on while stop waits", r, 32'h1);
        core_insn_done = 1'b1;
        @(negedge clk);
        core_insn_done = 1'b0;
        check("R4 core off after done", {31'b0, core_clk_en}, 32'h0);
        bus_read(5'h08, r);
        check("R1 core status off", r, 32'h0);
        bus_write(5'h00, 32'h1);
        check("R3 core set wakes", {31'b0, core_clk_en}, 32'h1);
    endtask

    task automatic t_irq_wake();
        stop_core();
        check("R5 core off before irq", {31'b0, core_clk_en}, 32'h0);
        irq_pend[17] = 1'b1;
        @(negedge clk);
        irq_pend = '0;
        check("R5 irq wakes core", {31'b0, core_clk_en}, 32'h1);
    endtask

    task automatic t_cancel();
        bus_write(5'h04, 32'h1);
        irq_pend[3] = 1'b1;
        @(negedge clk);
        irq_pend = '0;
        repeat (2) @(negedge clk);
        core_insn_done = 1'b1;
        @(negedge clk);
        core_insn_done = 1'b0;
        check("R6 irq cancels waiting stop", {31'b0, core_clk_en}, 32'h1);
    endtask

    task automatic t_same_cycle();
        bus_write(5'h04, 32'h1);
        irq_pend[0] = 1'b1;
        core_insn_done = 1'b1;
        @(negedge clk);
        irq_pend = '0;
        core_insn_done = 1'b0;
        check("R10 irq beats done", {31'b0, core_clk_en}, 32'h1);
        core_insn_done = 1'b1;
        @(negedge clk);
        core_insn_done = 1'b0;
        check("R10 stop fully cancelled", {31'b0, core_clk_en}, 32'h1);
        irq_pend[9] = 1'b1;
        bus_write(5'h04, 32'h1);
        core_insn_done = 1'b1;
        @(negedge clk);
        core_insn_done = 1'b0;
        irq_pend = '0;
        check("R10 clear during pending irq keeps core on", {31'b0, core_clk_en}, 32'h1);
    endtask

    task automatic t_periph();
        logic [DW-1:0] r;
        bus_write(5'h10, 32'h0000_00A5);
        check("R7 periph set", per_clk_en, 32'h0000_00A5);
        bus_write(5'h10, 32'h0);
        check("R8 zero set ignored", per_clk_en, 32'h0000_00A5);
        bus_write(5'h10, 32'h8000_0100);
        check("R7 periph set top bit", per_clk_en, 32'h8000_01A5);
        bus_write(5'h14, 32'h0000_0021);
        check("R7 periph clear", per_clk_en, 32'h8000_0184);
        bus_write(5'h14, 32'h0);
        check("R8 zero clear ignored", per_clk_en, 32'h8000_0184);
        bus_write(5'h00, 32'h0);
        check("R8 zero core set ignored", {31'b0, core_clk_en}, 32'h1);
        bus_write(5'h04, 32'h0);
        core_insn_done = 1'b1;
        @(negedge clk);
        core_insn_done = 1'b0;
        check("R8 zero core clear ignored", {31'b0, core_clk_en}, 32'h1);
        bus_read(5'h18, r);
        check("R1 periph status read", r, 32'h8000_0184);
    endtask

    task automatic t_core_off_periph();
        stop_core();
        check("R9 periph kept while core off", per_clk_en, 32'h8000_0184);
        bus_write(5'h10, 32'h0000_0002);
        check("R9 periph set while core off", per_clk_en, 32'h8000_0186);
        check("R9 core still off", {31'b0, core_clk_en}, 32'h0);
        bus_write(5'h00, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] r;
        bus_write(5'h11, 32'hFFFF_FFFF);
        check("R11 unaligned write ignored", per_clk_en, 32'h8000_0186);
        bus_write(5'h18, 32'hFFFF_FFFF);
        check("R11 status write ignored", per_clk_en, 32'h8000_0186);
        bus_write(5'h0C, 32'hFFFF_FFFF);
        check("R11 unmapped write ignored", per_clk_en, 32'h8000_0186);
        bus_read(5'h0C, r);
        check("R11 unmapped read zero", r, 32'h0);
        bus_read(5'h10, r);
        check("R11 set register reads zero", r, 32'h0);
        bus_read(5'h1A, r);
        check("R11 unaligned read zero", r, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_core_stop();
        t_irq_wake();
        t_cancel();
        t_same_cycle();
        t_periph();
        t_core_off_periph();
        t_unmapped();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule